// File: doc/BRIEF.md
# Enclave Segment and Target Validator

This block checks, in one pass, the thread-local segment layout and the entry point that an enclave entry is about to install. It takes the enclave base address and the base-relative offsets for the FS and GS segments and the entry instruction pointer. It adds each offset to the base. It then checks the results against the current operating width, which is 32-bit or 64-bit addressing. In 32-bit mode each segment's end must lie inside the data segment, and a segment that wraps around is accepted only when the data segment spans the full 4 GiB. In 64-bit mode every computed address must be canonical.

When every check passes, the block reports success together with the entry target address and two fully formed segment descriptors, which the entry sequence loads into FS and GS. Each descriptor has fixed type and presence fields and inherits its remaining attributes from the current data segment. A request is a one-cycle strobe. The verdict and all result fields appear together one clock later, marked by a one-cycle valid pulse, and they hold until the next request.

Top module: `enclave_seg_validator`

## Requirements
- R1: While rst_ni is low and after its release until the first request, res_valid_o, fault_o, target_o, fs_desc_o and gs_desc_o are all zero.
- R2: A request sampled on req_valid_i at a rising edge produces exactly one res_valid_o pulse in the following cycle. All result outputs change only on such a pulse and hold their values between requests.
- R3: If bits 11:0 of the FS offset or of the GS offset are nonzero, fault_o is 1. This applies in both modes.
- R4: In 32-bit mode (mode64_i=0) each segment is handled separately. Its base is (offset + enclave base) mod 2^32 and its end is (base + limit) mod 2^32. When end >= base, the result faults if end > ds_limit_i; end equal to ds_limit_i passes.
- R5: In 32-bit mode, a segment whose end is below its base is a wrap-around. A wrap-around passes only when ds_limit_i is 0xFFFFFFFF, and faults otherwise.
- R6: In 64-bit mode each segment base is offset + enclave base and must be canonical, meaning bits 63..47 are all equal. The ds_limit_i input and the segment limits have no effect on the verdict in this mode.
- R7: The target is entry offset + enclave base. In 64-bit mode it must be canonical, and target_o carries all 64 bits. In 32-bit mode its low 32 bits must not exceed cs_limit_i, and target_o carries those bits zero-extended.
- R8: On a pass, each descriptor packs these fields from MSB to LSB: selector[125:110]=0x000B, base[109:46], limit[45:14], type[13:10]=0001b, w[9], s[8]=1, dpl[7:6], p[5]=1, avl[4], l[3], b[2]=1, g[1]=1, unusable[0]=0. The w, dpl, avl and l fields are copied from the DS attribute inputs. The limit field is the segment's limit input. The base is 64 bits in 64-bit mode and zero-extended to 64 bits in 32-bit mode.
- R9: On a fault, fault_o is 1 and target_o, fs_desc_o and gs_desc_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle request strobe |
| mode64_i | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| encl_base_i | input | 64 | Enclave base address |
| fs_ofs_i | input | 64 | FS base offset from enclave base |
| gs_ofs_i | input | 64 | GS base offset from enclave base |
| fs_lim_i | input | 32 | FS limit field |
| gs_lim_i | input | 32 | GS limit field |
| entry_ofs_i | input | 64 | Entry point offset from enclave base |
| ds_limit_i | input | 32 | Current data-segment limit |
| cs_limit_i | input | 32 | Current code-segment limit |
| ds_w_i | input | 1 | DS writable attribute |
| ds_dpl_i | input | 2 | DS privilege level |
| ds_avl_i | input | 1 | DS available bit |
| ds_l_i | input | 1 | DS long-mode bit |
| res_valid_o | output | 1 | One-cycle result pulse |
| fault_o | output | 1 | 1 = general-protection fault |
| target_o | output | 64 | Entry target address |
| fs_desc_o | output | 126 | Packed FS descriptor |
| gs_desc_o | output | 126 | Packed GS descriptor |

## Verification
Every result, including the verdict, the target and both descriptors, is registered once. All of them are due in the cycle after the rising edge that samples the request. The driver pushes the expected item while it raises the strobe. The monitor samples at the falling edge, pops one item for each res_valid_o pulse and counts a pulse with nothing pending as a failure. After a request the bench leaves idle cycles and compares the outputs again, which shows that they hold until the next strobe.

// File: rtl/seg_val_pkg.sv
package seg_val_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned LIM_W  = 32;
  localparam int unsigned SEL_W  = 16;

  localparam logic [SEL_W-1:0] SEG_SEL  = 16'h000B;
  localparam logic [3:0]       SEG_TYPE = 4'b0001;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [3:0]        typ;
    logic              w;
    logic              s;
    logic [1:0]        dpl;
    logic              p;
    logic              avl;
    logic              l;
    logic              b;
    logic              g;
    logic              unusable;
  } seg_desc_t;

  localparam int unsigned DESC_W = $bits(seg_desc_t);

  // bits ADDR_W-1 down to va-1 must all match
  function automatic logic is_canonical(logic [ADDR_W-1:0] a, int unsigned va);
    logic [ADDR_W-1:0] hi_mask;
    hi_mask = ~((ADDR_W'(1) << (va - 1)) - ADDR_W'(1));
    return ((a & hi_mask) == hi_mask) || ((a & hi_mask) == '0);
  endfunction
endpackage

// File: rtl/seg_check.sv
module seg_check
  import seg_val_pkg::*;
#(
  parameter int unsigned VA_BITS   = 48,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              mode64_i,
  input  logic [ADDR_W-1:0] encl_base_i,
  input  logic [ADDR_W-1:0] ofs_i,
  input  logic [LIM_W-1:0]  lim_i,
  input  logic [LIM_W-1:0]  ds_limit_i,
  input  logic              ds_w_i,
  input  logic [1:0]        ds_dpl_i,
  input  logic              ds_avl_i,
  input  logic              ds_l_i,
  output logic              ok_o,
  output seg_desc_t         desc_o
);
  localparam int unsigned PAD_W = ADDR_W - LIM_W;

  logic [ADDR_W-1:0] base_full;
  logic [LIM_W-1:0]  base_lo, end_lo;
  logic              aligned, wrap, fit;

  always_comb begin
    base_full = ofs_i + encl_base_i;
    base_lo   = base_full[LIM_W-1:0];
    end_lo    = base_lo + lim_i;
    aligned   = (ofs_i[PAGE_BITS-1:0] == '0);
    wrap      = (end_lo < base_lo);
    // wrap-around needs a full-span DS with no holes
    fit       = wrap ? (&ds_limit_i) : (end_lo <= ds_limit_i);
    ok_o      = aligned & (mode64_i ? is_canonical(base_full, VA_BITS) : fit);
  end

  always_comb begin
    desc_o          = '0;
    desc_o.sel      = SEG_SEL;
    desc_o.base     = mode64_i ? base_full : {{PAD_W{1'b0}}, base_lo};
    desc_o.limit    = lim_i;
    desc_o.typ      = SEG_TYPE;
    desc_o.w        = ds_w_i;
    desc_o.s        = 1'b1;
    desc_o.dpl      = ds_dpl_i;
    desc_o.p        = 1'b1;
    desc_o.avl      = ds_avl_i;
    desc_o.l        = ds_l_i;
    desc_o.b        = 1'b1;
    desc_o.g        = 1'b1;
    desc_o.unusable = 1'b0;
  end
endmodule

// File: rtl/target_check.sv
module target_check
  import seg_val_pkg::*;
#(
  parameter int unsigned VA_BITS = 48
) (
  input  logic              mode64_i,
  input  logic [ADDR_W-1:0] encl_base_i,
  input  logic [ADDR_W-1:0] entry_ofs_i,
  input  logic [LIM_W-1:0]  cs_limit_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned PAD_W = ADDR_W - LIM_W;

  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum = entry_ofs_i + encl_base_i;
    if (mode64_i) begin
      ok_o     = is_canonical(sum, VA_BITS);
      target_o = sum;
    end else begin
      ok_o     = (sum[LIM_W-1:0] <= cs_limit_i);
      target_o = {{PAD_W{1'b0}}, sum[LIM_W-1:0]};
    end
  end
endmodule

// File: rtl/enclave_seg_validator.sv
module enclave_seg_validator
  import seg_val_pkg::*;
#(
  parameter int unsigned VA_BITS   = 48,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              mode64_i,
  input  logic [ADDR_W-1:0] encl_base_i,
  input  logic [ADDR_W-1:0] fs_ofs_i,
  input  logic [ADDR_W-1:0] gs_ofs_i,
  input  logic [LIM_W-1:0]  fs_lim_i,
  input  logic [LIM_W-1:0]  gs_lim_i,
  input  logic [ADDR_W-1:0] entry_ofs_i,
  input  logic [LIM_W-1:0]  ds_limit_i,
  input  logic [LIM_W-1:0]  cs_limit_i,
  input  logic              ds_w_i,
  input  logic [1:0]        ds_dpl_i,
  input  logic              ds_avl_i,
  input  logic              ds_l_i,
  output logic              res_valid_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [DESC_W-1:0] fs_desc_o,
  output logic [DESC_W-1:0] gs_desc_o
);
  localparam int unsigned NUM_SEG = 2;

  logic [NUM_SEG-1:0][ADDR_W-1:0] seg_ofs;
  logic [NUM_SEG-1:0][LIM_W-1:0]  seg_lim;
  logic [NUM_SEG-1:0]             seg_ok;
  seg_desc_t                      seg_desc [NUM_SEG];

  assign seg_ofs = {gs_ofs_i, fs_ofs_i};
  assign seg_lim = {gs_lim_i, fs_lim_i};

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    seg_check #(
      .VA_BITS  (VA_BITS),
      .PAGE_BITS(PAGE_BITS)
    ) i_seg_check (
      .mode64_i   (mode64_i),
      .encl_base_i(encl_base_i),
      .ofs_i      (seg_ofs[g]),
      .lim_i      (seg_lim[g]),
      .ds_limit_i (ds_limit_i),
      .ds_w_i     (ds_w_i),
      .ds_dpl_i   (ds_dpl_i),
      .ds_avl_i   (ds_avl_i),
      .ds_l_i     (ds_l_i),
      .ok_o       (seg_ok[g]),
      .desc_o     (seg_desc[g])
    );
  end

  logic              tgt_ok;
  logic [ADDR_W-1:0] tgt;

  target_check #(
    .VA_BITS(VA_BITS)
  ) i_target_check (
    .mode64_i   (mode64_i),
    .encl_base_i(encl_base_i),
    .entry_ofs_i(entry_ofs_i),
    .cs_limit_i (cs_limit_i),
    .ok_o       (tgt_ok),
    .target_o   (tgt)
  );

  logic pass;
  assign pass = (&seg_ok) & tgt_ok;

  logic              valid_q, fault_q;
  logic [ADDR_W-1:0] target_q;
  seg_desc_t         fs_q, gs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      fault_q  <= 1'b0;
      target_q <= '0;
      fs_q     <= '0;
      gs_q     <= '0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) begin
        fault_q  <= ~pass;
        target_q <= pass ? tgt : '0;
        fs_q     <= pass ? seg_desc[0] : '0;
        gs_q     <= pass ? seg_desc[1] : '0;
      end
    end
  end

  assign res_valid_o = valid_q;
  assign fault_o     = fault_q;
  assign target_o    = target_q;
  assign fs_desc_o   = fs_q;
  assign gs_desc_o   = gs_q;

  a_r2_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(req_valid_i));

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !req_valid_i) |=> !res_valid_o);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(fault_o) && $stable(target_o) && $stable(fs_desc_o)));

  a_r3_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && (($past(fs_ofs_i[PAGE_BITS-1:0]) != '0) ||
                     ($past(gs_ofs_i[PAGE_BITS-1:0]) != '0))) |-> fault_o);

  a_r8_fixed_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !fault_o) |-> (fs_q.sel == SEG_SEL && gs_q.sel == SEG_SEL &&
      fs_q.typ == SEG_TYPE && gs_q.typ == SEG_TYPE && fs_q.p && gs_q.p &&
      !fs_q.unusable && !gs_q.unusable));

  a_r9_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && fault_o) |-> (target_o == '0 && fs_desc_o == '0 && gs_desc_o == '0));
endmodule

// File: tb/test_enclave_seg_validator.sv
module test_enclave_seg_validator;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req = 1'b0;
  logic         mode64 = 1'b0;
  logic [63:0]  base = '0, fs_ofs = '0, gs_ofs = '0, entry = '0;
  logic [31:0]  fs_lim = '0, gs_lim = '0, ds_lim = '0, cs_lim = '0;
  logic         ds_w = 1'b0, ds_avl = 1'b0, ds_l = 1'b0;
  logic [1:0]   ds_dpl = '0;

  logic         res_valid, fault;
  logic [63:0]  target;
  logic [125:0] fs_desc, gs_desc;

  always #(CLK_PERIOD/2) clk = ~clk;

  enclave_seg_validator i_enclave_seg_validator (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req), .mode64_i(mode64),
    .encl_base_i(base), .fs_ofs_i(fs_ofs), .gs_ofs_i(gs_ofs),
    .fs_lim_i(fs_lim), .gs_lim_i(gs_lim), .entry_ofs_i(entry),
    .ds_limit_i(ds_lim), .cs_limit_i(cs_lim), .ds_w_i(ds_w),
    .ds_dpl_i(ds_dpl), .ds_avl_i(ds_avl), .ds_l_i(ds_l),
    .res_valid_o(res_valid), .fault_o(fault), .target_o(target),
    .fs_desc_o(fs_desc), .gs_desc_o(gs_desc)
  );

  typedef struct {
    logic         flt;
    logic [63:0]  tgt;
    logic [125:0] fs;
    logic [125:0] gs;
    string        tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   n_run = 0;
  int   n_fail = 0;

  function automatic logic canon(logic [63:0] a);
    return (&a[63:47]) || !(|a[63:47]);
  endfunction

  function automatic void seg_model(input logic [63:0] ofs, input logic [31:0] lim,
                                    output logic ok, output logic [125:0] d);
    logic [63:0] full;
    logic [31:0] b32, e32;
    logic [63:0] bout;
    full = ofs + base;
    b32  = full[31:0];
    e32  = b32 + lim;
    ok   = (ofs[11:0] == 12'h0);
    if (mode64) begin
      ok   = ok && canon(full);
      bout = full;
    end else begin
      if (e32 < b32) ok = ok && (ds_lim == 32'hFFFF_FFFF);
      else           ok = ok && (e32 <= ds_lim);
      bout = {32'h0, b32};
    end
    d = {16'h000B, bout, lim, 4'b0001, ds_w, 1'b1, ds_dpl, 1'b1, ds_avl, ds_l,
         1'b1, 1'b1, 1'b0};
  endfunction

  task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(string tag);
    exp_t e;
    logic fok, gok, tok;
    logic [63:0] t;
    seg_model(fs_ofs, fs_lim, fok, e.fs);
    seg_model(gs_ofs, gs_lim, gok, e.gs);
    t = entry + base;
    if (mode64) tok = canon(t);
    else begin
      tok = (t[31:0] <= cs_lim);
      t   = {32'h0, t[31:0]};
    end
    e.flt = !(fok && gok && tok);
    e.tgt = e.flt ? 64'h0 : t;
    if (e.flt) begin
      e.fs = '0;
      e.gs = '0;
    end
    e.tag = tag;
    q.push_back(e);
    last = e;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
  endtask

  // monitor: results are due one cycle after the strobe
  always @(negedge clk) begin
    if (rst_ni && res_valid) begin
      if (q.size() == 0) begin
        n_run++;
        n_fail++;
        $display("FAIL R2 unexpected res_valid pulse: actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "fault", {127'h0, fault}, {127'h0, e.flt});
        check(e.tag, "target", {64'h0, target}, {64'h0, e.tgt});
        check(e.tag, "fs_desc", {2'b0, fs_desc}, {2'b0, e.fs});
        check(e.tag, "gs_desc", {2'b0, gs_desc}, {2'b0, e.gs});
      end
    end
  end

  task automatic hold_check(string tag);
    repeat (3) @(negedge clk);
    check(tag, "hold res_valid", {127'h0, res_valid}, 128'h0);
    check(tag, "hold fault", {127'h0, fault}, {127'h0, last.flt});
    check(tag, "hold target", {64'h0, target}, {64'h0, last.tgt});
    check(tag, "hold fs_desc", {2'b0, fs_desc}, {2'b0, last.fs});
  endtask

  task automatic set32_default();
    mode64 = 1'b0;
    base   = 64'h0001_0000;
    fs_ofs = 64'h1000;
    gs_ofs = 64'h2000;
    fs_lim = 32'hFFF;
    gs_lim = 32'hFFF;
    entry  = 64'h100;
    ds_lim = 32'h000F_FFFF;
    cs_lim = 32'h000F_FFFF;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "valid in reset", {127'h0, res_valid}, 128'h0);
    check("R1", "fault in reset", {127'h0, fault}, 128'h0);
    check("R1", "target in reset", {64'h0, target}, 128'h0);
    check("R1", "fs_desc in reset", {2'b0, fs_desc}, 128'h0);
    check("R1", "gs_desc in reset", {2'b0, gs_desc}, 128'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "valid after reset", {127'h0, res_valid}, 128'h0);

    // R4 R8 R7: 32-bit pass
    set32_default();
    ds_w = 1'b1; ds_dpl = 2'd3; ds_avl = 1'b0; ds_l = 1'b0;
    send("R4_R7_R8_pass32");
    hold_check("R2");

    // R8: other DS attributes
    ds_w = 1'b0; ds_dpl = 2'd1; ds_avl = 1'b1; ds_l = 1'b1;
    send("R8_attr_copy");

    // R4 boundary: end equals DS limit passes, one beyond faults
    gs_ofs = 64'h1000;
    ds_lim = 32'h0001_1FFF;
    send("R4_end_eq_limit");
    ds_lim = 32'h0001_1FFE;
    send("R4_end_over_limit_R9");
    hold_check("R9");

    // R5 wrap-around
    set32_default();
    base   = 64'hFFFF_0000;
    fs_ofs = 64'h0;
    fs_lim = 32'h0002_0000;
    entry  = 64'h0;
    cs_lim = 32'hFFFF_FFFF;
    ds_lim = 32'hFFFF_FFFF;
    send("R5_wrap_full_ds");
    ds_lim = 32'hFFFF_FFFE;
    send("R5_wrap_short_ds");

    // R3 alignment in both modes
    set32_default();
    fs_ofs = 64'h1800;
    send("R3_fs_misaligned32");
    fs_ofs = 64'h1000;
    gs_ofs = 64'h2001;
    send("R3_gs_misaligned32");

    // R6 64-bit
    mode64 = 1'b1;
    base   = 64'h0000_7FFF_FFFF_0000;
    fs_ofs = 64'h1000;
    gs_ofs = 64'h2000;
    entry  = 64'h10;
    ds_lim = 32'h0;
    cs_lim = 32'h0;
    fs_lim = 32'hFFFF_FFFF;
    send("R6_R7_pass64_limits_ignored");
    gs_ofs = 64'h1_0000;
    send("R6_gs_noncanonical");
    gs_ofs = 64'h2000;
    fs_ofs = 64'h1800;
    send("R3_fs_misaligned64");

    // R7 target
    base   = 64'hFFFF_8000_0000_0000;
    fs_ofs = 64'h0; gs_ofs = 64'h0; entry = 64'h40;
    send("R7_R6_upper_canonical");
    base   = 64'h0000_7FFF_FFFF_F000;
    fs_ofs = 64'h0; gs_ofs = 64'h0; entry = 64'h1000;
    send("R7_target_noncanonical");
    set32_default();
    entry  = 64'hF_0000;
    cs_lim = 32'h000F_FFFF;
    base   = 64'h0;
    fs_ofs = 64'h1000; gs_ofs = 64'h2000;
    entry  = 64'hF_FFFF;
    send("R7_target_eq_cs");
    entry  = 64'h10_0000;
    send("R7_target_over_cs");
    hold_check("R2");

    check("R2", "pending results", 128'(q.size()), 128'h0);
    finish_run();
  end
endmodule